// File: doc/BRIEF.md
# Divide-by-16 Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Each frame is ten bit times long: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The bit rate comes from an external `baud_tick` strobe that lasts one clock cycle, and the block divides it by 16. The transmitter's divider runs freely from reset, so every transmitted bit edge falls on one of its rollovers and not on the cycle of the write. Transmit completion is found by following a marker bit through the shift register.

Software-side logic starts a transmission by pulsing `wr_en` with a byte. It learns that the frame has gone out when `tx_flag` rises. The receiver is armed by `rx_en`. It finds a start edge on `rxd` and samples each bit at its middle. When the frame completes it delivers the byte, the stop-bit level and `rx_flag`. Both flags stay set until they are cleared by their clear strobes.

Top module: `uart16_core`

## Requirements
- R1: `txd` sends each frame as one low bit, then data bit 0 up to data bit 7, then a high stop bit. Each bit lasts 16 baud ticks.
- R2: The falling edge that starts a frame on `txd` comes in the cycle after the transmit divider rolls over, that is, after every 16th baud tick counted from reset. It is the first such rollover after the write is accepted.
- R3: `tx_flag` rises 144 baud ticks (9 bit times) after the start edge, on the tenth rollover counted from the one that began the frame. It stays high until a `clr_tx_flag` pulse clears it on the next edge.
- R4: A write that arrives while a request is pending or a frame is being sent is ignored. The frame in progress is unchanged, and no further frame follows it.
- R5: During reset, `txd` is 1, both flags are 0, and `rx_data` and `rx_stop` are 0. `txd` also stays 1 whenever no frame is in progress.
- R6: A frame received while `rx_enable` is high and `rx_flag` is clear loads its eight data bits into `rx_data` (the first bit received lands in bit 0) and sets `rx_flag`.
- R7: `rx_stop` takes the level sampled in the stop-bit position: 1 for a well-formed frame and 0 when the stop bit is low.
- R8: A low pulse on `rxd` that is high again at the middle of the start bit is dropped. No flag is set, and the next real frame is received normally.
- R9: A frame that completes while `rx_flag` is set is discarded, and `rx_data` and `rx_stop` keep their earlier values.
- R10: While `rx_en` is low, a frame on `rxd` is not received, and `rx_flag` stays 0.
- R11: A `clr_rx_flag` pulse clears `rx_flag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rx_en | input | 1 | Arms the receiver |
| rxd | input | 1 | Serial input |
| clr_tx_flag | input | 1 | Clears the transmit-done flag |
| clr_rx_flag | input | 1 | Clears the receive-done flag |
| txd | output | 1 | Serial output, idles high |
| tx_flag | output | 1 | Frame transmitted |
| rx_data | output | 8 | Last received byte |
| rx_stop | output | 1 | Stop-bit level of the last received frame |
| rx_flag | output | 1 | Byte received |

## Verification
Transmit is driven with the bytes A5, 3C, FF and 01. Alternating, grouped and all-ones patterns expose any bit-order or shift-direction error. The single-one pattern checks that the marker bit cannot be confused with a data one. Receive uses 5A with a good stop bit and C3 with a low stop bit, which separates the data path from the stop-bit status. A second frame that arrives while the flag is set, a short start glitch, and a frame sent while the receiver is disarmed show that each of these leaves the stored byte untouched.

// File: rtl/uart16_pkg.sv
`timescale 1ns/1ps
package uart16_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart16_rst_sync.sv
`timescale 1ns/1ps
module uart16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/uart16_tx.sv
`timescale 1ns/1ps
module uart16_tx
  import uart16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_flag,
  output logic              txd,
  output logic              tx_flag
);
  localparam int CNT_W = $clog2(OVS);
  localparam int SH_W  = DATA_W + 1;

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic             req_q, req_d;
  logic             flag_q, flag_d;
  logic             roll, busy, last, flag_set;

  assign roll = baud_tick && (cnt_q == CNT_W'(OVS-1));
  assign busy = req_q || (state_q != TX_IDLE);
  assign last = (sh_q[SH_W-1:1] == {{(DATA_W-1){1'b0}}, 1'b1});

  always_comb begin
    cnt_d    = cnt_q;
    state_d  = state_q;
    sh_d     = sh_q;
    req_d    = req_q;
    flag_set = 1'b0;
    if (baud_tick) cnt_d = roll ? '0 : cnt_q + 1'b1;
    if (wr_en && !busy) begin
      sh_d  = {1'b1, wr_data};
      req_d = 1'b1;
    end
    if (roll) begin
      case (state_q)
        TX_IDLE: if (req_q) begin
          state_d = TX_START;
          req_d   = 1'b0;
        end
        TX_START: state_d = TX_DATA;
        TX_DATA: begin
          sh_d = {1'b0, sh_q[SH_W-1:1]};
          if (last) begin
            state_d  = TX_IDLE;
            flag_set = 1'b1;
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end
    flag_d = flag_set ? 1'b1 : (clr_flag ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
      req_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      req_q   <= req_d;
      flag_q  <= flag_d;
    end
  end

  assign txd     = (state_q == TX_DATA) ? sh_q[0] : (state_q != TX_START);
  assign tx_flag = flag_q;

  // R2
  tx_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_START && $past(state_q) == TX_IDLE) |->
      ($past(baud_tick) && $past(cnt_q) == CNT_W'(OVS-1)));

  // R3
  tx_flag_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> ($past(baud_tick) && $past(state_q) == TX_DATA));

  // R4
  tx_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !roll) |=> $stable(sh_q));
endmodule

// File: rtl/uart16_rx.sv
`timescale 1ns/1ps
module uart16_rx
  import uart16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              clr_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stop,
  output logic              rx_flag
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BC_W  = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic              stop_q, stop_d, flag_q, flag_d, set;
  logic [1:0]        sync_q;
  logic              prev_q, rxs, fall, mid;

  assign rxs  = sync_q[1];
  assign fall = prev_q && !rxs;
  assign mid  = baud_tick && (cnt_q == CNT_W'(OVS/2 - 1));

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    data_d  = data_q;
    stop_d  = stop_q;
    set     = 1'b0;
    cnt_d   = cnt_q;
    if (baud_tick) cnt_d = (cnt_q == CNT_W'(OVS-1)) ? '0 : cnt_q + 1'b1;
    case (state_q)
      RX_IDLE: if (rx_en && fall) begin
        state_d = RX_START;
        cnt_d   = '0;
      end
      RX_START: if (mid) begin
        state_d = rxs ? RX_IDLE : RX_DATA;
        bit_d   = '0;
      end
      RX_DATA: if (mid) begin
        sh_d  = {rxs, sh_q[DATA_W-1:1]};
        bit_d = bit_q + 1'b1;
        if (bit_q == BC_W'(DATA_W-1)) state_d = RX_STOP;
      end
      RX_STOP: if (mid) begin
        state_d = RX_IDLE;
        if (!flag_q) begin
          data_d = sh_q;
          stop_d = rxs;
          set    = 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
    flag_d = set ? 1'b1 : (clr_flag ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      stop_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      prev_q  <= rxs;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      stop_q  <= stop_d;
      flag_q  <= flag_d;
    end
  end

  assign rx_data = data_q;
  assign rx_stop = stop_q;
  assign rx_flag = flag_q;

  // R8
  rx_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && mid && rxs) |=> (state_q == RX_IDLE));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !clr_flag) |=> ($stable(rx_data) && $stable(rx_stop)));

  // R6
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> ($past(state_q) == RX_STOP));

  // R10
  rx_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !rx_en) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/uart16_core.sv
`timescale 1ns/1ps
module uart16_core #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              clr_tx_flag,
  input  logic              clr_rx_flag,
  output logic              txd,
  output logic              tx_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stop,
  output logic              rx_flag
);
  logic rst_n_i;

  uart16_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n(rst_n_i));

  uart16_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .clr_flag(clr_tx_flag), .txd(txd), .tx_flag(tx_flag));

  uart16_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .baud_tick(baud_tick), .rx_en(rx_en),
    .rxd(rxd), .clr_flag(clr_rx_flag), .rx_data(rx_data), .rx_stop(rx_stop),
    .rx_flag(rx_flag));
endmodule

// File: tb/uart16_core_bench.sv
`timescale 1ns/1ps
module uart16_core_bench;
  logic       clk, rst_n, baud_tick, wr_en, rx_en, rxd, clr_tx_flag, clr_rx_flag;
  logic [7:0] wr_data, rx_data;
  logic       txd, tx_flag, rx_stop, rx_flag;
  int n_run = 0, n_fail = 0;
  int cyc = 0, ticks = 0, last_roll = -1;

  uart16_core u_uart16_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rx_en(rx_en), .rxd(rxd), .clr_tx_flag(clr_tx_flag),
    .clr_rx_flag(clr_rx_flag), .txd(txd), .tx_flag(tx_flag),
    .rx_data(rx_data), .rx_stop(rx_stop), .rx_flag(rx_flag));

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // tick bookkeeping: a rollover is every 16th tick since reset
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (baud_tick) begin
      ticks = ticks + 1;
      if (ticks % 16 == 0) last_roll = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(txd == 1'b1, "R5 txd", txd, 1);
    chk(tx_flag == 1'b0 && rx_flag == 1'b0, "R5 flags", {tx_flag, rx_flag}, 0);
    chk(rx_data == 8'h00 && rx_stop == 1'b0, "R5 rx regs", {rx_stop, rx_data}, 0);
  endtask

  task automatic tx_frame(input logic [7:0] b, input bit busy_wr);
    int wcyc, st;
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; wcyc = cyc;
    for (int k = 0; k < 300 && txd; k++) @(negedge clk);
    st = cyc;
    chk(txd == 1'b0, "R2 start seen", txd, 0);
    chk(last_roll == st, "R2 start on rollover", last_roll, st);
    chk(st - wcyc <= 65, "R2 first rollover", st - wcyc, 64);
    wait_n(32);
    chk(txd == 1'b0, "R1 start bit", txd, 0);
    if (busy_wr) begin
      wr_en = 1'b1; wr_data = ~b;
      @(negedge clk); wr_en = 1'b0;
      wait_n(63);
    end else wait_n(64);
    for (int i = 0; i < 8; i++) begin
      chk(txd == b[i], "R1 data bit", txd, b[i]);
      if (i < 7) wait_n(64);
    end
    wait_n(31);
    chk(tx_flag == 1'b0, "R3 flag not early", tx_flag, 0);
    wait_n(1);
    chk(tx_flag == 1'b1, "R3 flag at tenth rollover", tx_flag, 1);
    wait_n(32);
    chk(txd == 1'b1, "R1 stop bit", txd, 1);
    clr_tx_flag = 1'b1;
    @(negedge clk); clr_tx_flag = 1'b0;
    chk(tx_flag == 1'b0, "R3 flag cleared", tx_flag, 0);
    if (busy_wr) begin
      bit low_seen = 1'b0;
      for (int k = 0; k < 1400; k++) begin
        @(negedge clk);
        if (!txd) low_seen = 1'b1;
      end
      chk(!low_seen, "R4 no extra frame", low_seen, 0);
      chk(txd == 1'b1, "R5 idle high", txd, 1);
    end
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stopb);
    rxd = 1'b0; wait_n(64);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; wait_n(64);
    end
    rxd = stopb; wait_n(64);
    rxd = 1'b1; wait_n(8);
  endtask

  task automatic clr_rx();
    clr_rx_flag = 1'b1;
    @(negedge clk); clr_rx_flag = 1'b0;
    chk(rx_flag == 1'b0, "R11 rx flag cleared", rx_flag, 0);
  endtask

  task automatic test_rx_good();
    rx_send(8'h5A, 1'b1);
    chk(rx_flag == 1'b1, "R6 rx flag", rx_flag, 1);
    chk(rx_data == 8'h5A, "R6 rx data", rx_data, 8'h5A);
    chk(rx_stop == 1'b1, "R7 stop high", rx_stop, 1);
    clr_rx();
  endtask

  task automatic test_rx_stop_low_overrun();
    rx_send(8'hC3, 1'b0);
    rxd = 1'b1; wait_n(64);
    chk(rx_data == 8'hC3, "R6 rx data C3", rx_data, 8'hC3);
    chk(rx_stop == 1'b0, "R7 stop low", rx_stop, 0);
    rx_send(8'h11, 1'b1);
    chk(rx_data == 8'hC3, "R9 data kept", rx_data, 8'hC3);
    chk(rx_stop == 1'b0, "R9 stop kept", rx_stop, 0);
    clr_rx();
  endtask

  task automatic test_glitch();
    rxd = 1'b0; wait_n(12);
    rxd = 1'b1; wait_n(1280);
    chk(rx_flag == 1'b0, "R8 glitch dropped", rx_flag, 0);
    rx_send(8'h96, 1'b1);
    chk(rx_flag == 1'b1 && rx_data == 8'h96, "R8 next frame", rx_data, 8'h96);
    clr_rx();
  endtask

  task automatic test_disarmed();
    rx_en = 1'b0;
    rx_send(8'h77, 1'b1);
    wait_n(64);
    chk(rx_flag == 1'b0, "R10 no flag", rx_flag, 0);
    chk(rx_data == 8'h96, "R10 data kept", rx_data, 8'h96);
    rx_en = 1'b1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    baud_tick = 1'b0;
    @(posedge rst_n);
    repeat (5) @(negedge clk);
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rx_en = 1'b1; rxd = 1'b1;
    clr_tx_flag = 1'b0; clr_rx_flag = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    wait_n(2);
    rst_n = 1'b1;
    wait_n(10);
    tx_frame(8'hA5, 1'b0);
    tx_frame(8'h3C, 1'b1);
    tx_frame(8'hFF, 1'b0);
    tx_frame(8'h01, 1'b0);
    test_rx_good();
    test_rx_stop_low_overrun();
    test_glitch();
    test_disarmed();
    finish_run();
  end
endmodule